// File: doc/BRIEF.md
# Serial Configuration Readback Controller

This block sends stored configuration frames out one bit per clock on a single serial data line. Software or a test fixture holds an active-low read request. Once the request falls, the controller waits a fixed number of idle cycles and then streams every frame in turn. Each frame starts with a marker pair so a receiver can lock onto it. It then carries the frame's configuration word and, optionally, a snapshot of captured logic-output state. The configuration words are read from an external frame memory through a synchronous read port with one cycle of latency.

A two-bit permission setting decides whether requests are served. One setting refuses every request, one serves only the first readback after reset, and the remaining settings serve every request. Releasing the request aborts the stream at once. A new falling edge restarts from frame 0, but only if the request was high for at least two clock edges. When the processor-port enable is asserted, this dedicated path is disabled entirely.

Top module: `cfg_readback`

## Requirements
- R1: While reset is held and in the cycle after it, `sd_out` is 1 and `mem_rd_en` is 0.
- R2: A readback starts only on a falling edge of `rd_req_n` that follows at least two clock edges at which `rd_req_n` was sampled high. A request held low from reset never starts one.
- R3: After the clock edge that samples the starting low request, `sd_out` is 1 for LATENCY cycles (default 4). The next cycle carries the first start bit.
- R4: Each frame is made of, in order: a 0 and then a 1; the FRAME_BITS memory word for that frame, MSB first; the STATE_BITS value of `state_in`, MSB first, when STATE_EN is 1; and two 1 stop bits. Exactly one bit is sent per clock.
- R5: Frames 0 to NUM_FRAMES-1 follow one another with no gap. After the last stop bit, `sd_out` stays 1.
- R6: `mem_rd_en` is a single-cycle pulse. `mem_addr` holds the frame index (always below NUM_FRAMES), and `mem_rd_data` is taken from the following cycle on.
- R7: A clock edge that samples `rd_req_n` high sets `sd_out` to 1 from the next cycle, and the stream stays stopped.
- R8: After an abort, holding the request high for two or more edges and then low replays the whole stream from frame 0, with the same latency.
- R9: A high pulse on `rd_req_n` that is sampled at only one edge does not start a new readback. `sd_out` stays 1.
- R10: With `perm_mode` = 2'b00, no request is ever served.
- R11: With `perm_mode` = 2'b01, only the first readback after reset is served. The permission is used up when that readback's first start bit is driven, and later falling edges produce only 1s until reset.
- R12: With `perm_mode` = 2'b10 or 2'b11, every qualifying falling edge is served.
- R13: While `port_en` is 1, `sd_out` is 1 from the next cycle, any running stream stops, and no falling edge starts a readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_n | input | 1 | Active-low read request |
| port_en | input | 1 | Processor-port enable; disables this readback path |
| perm_mode | input | 2 | 00 prohibit, 01 once, 1x unlimited |
| state_in | input | STATE_BITS | Captured logic-output state to append |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_addr | output | AW | Frame index to read |
| mem_rd_data | input | FRAME_BITS | Frame word, valid the cycle after the strobe |
| sd_out | output | 1 | Serial readback data, 1 when idle |

## Verification
A wrong latency count, bit position or frame counter shifts or corrupts the serial stream. Because every output bit is compared against a stream computed from the memory contents, such a fault shows up within the first frame. Faults in the permission flag or the high-period counter show up on the first request they wrongly serve or refuse. They appear as a 0 start bit where only 1s are expected, or as a stream of 1s where a start bit was due, about LATENCY+1 cycles after the falling edge. An abort path that does not stop the stream is caught on the cycle after the request rises.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;
  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_WAIT = 2'd1,
    SER_SEND = 2'd2
  } ser_state_t;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_ONCE = 2'b01;
endpackage

// File: rtl/rb_req_detect.sv
module rb_req_detect #(
  parameter int MIN_HIGH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req_n,
  output logic fall_ok
);
  localparam int CW = $clog2(MIN_HIGH + 1);

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= '0;
    end else if (!rd_req_n) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q != CW'(MIN_HIGH)) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign fall_ok = !rd_req_n && (hi_cnt_q == CW'(MIN_HIGH));
endmodule

// File: rtl/rb_permit.sv
module rb_permit
  import cfg_readback_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] perm_mode,
  input  logic       req_ok,
  input  logic       port_en,
  input  logic       first_start,
  output logic       go,
  output logic       used_q
);
  logic allowed;

  always_ff @(posedge clk) begin
    if (rst) used_q <= 1'b0;
    else if (first_start) used_q <= 1'b1;
  end

  always_comb begin
    if (perm_mode[1]) allowed = 1'b1;
    else if (perm_mode == PERM_ONCE) allowed = !used_q;
    else allowed = 1'b0;
  end

  assign go = req_ok && !port_en && allowed;
endmodule

// File: rtl/rb_serializer.sv
module rb_serializer
  import cfg_readback_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int STATE_BITS = 4,
  parameter bit STATE_EN   = 1'b1,
  parameter int NUM_FRAMES = 4,
  parameter int LATENCY    = 4,
  parameter int AW         = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic                  stop,
  input  logic [STATE_BITS-1:0] state_in,
  input  logic [FRAME_BITS-1:0] mem_rd_data,
  output logic                  mem_rd_en,
  output logic [AW-1:0]         mem_addr,
  output logic                  first_start,
  output logic                  busy,
  output logic                  sd_out
);
  localparam int SH_W   = FRAME_BITS + (STATE_EN ? STATE_BITS : 0);
  localparam int FL     = SH_W + 4;
  localparam int PW     = $clog2(FL);
  localparam int LW     = $clog2(LATENCY + 1);
  localparam int LAST_F = NUM_FRAMES - 1;

  ser_state_t      st_q;
  logic [PW-1:0]   pos_q;
  logic [LW-1:0]   lat_q;
  logic [AW-1:0]   frame_q;
  logic [AW-1:0]   rd_addr_q;
  logic            rd_en_q;
  logic            sd_q;
  logic            first_q;
  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] load_w;

  generate
    if (STATE_EN) begin : g_with_state
      assign load_w = {mem_rd_data, state_in};
    end else begin : g_cfg_only
      assign load_w = mem_rd_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SER_IDLE;
      pos_q     <= '0;
      lat_q     <= '0;
      frame_q   <= '0;
      rd_addr_q <= '0;
      rd_en_q   <= 1'b0;
      sd_q      <= 1'b1;
      first_q   <= 1'b0;
      sh_q      <= '0;
    end else begin
      rd_en_q <= 1'b0;
      first_q <= 1'b0;
      if (stop) begin
        st_q <= SER_IDLE;
        sd_q <= 1'b1;
      end else begin
        case (st_q)
          SER_IDLE: begin
            sd_q <= 1'b1;
            if (go) begin
              st_q      <= SER_WAIT;
              lat_q     <= '0;
              frame_q   <= '0;
              rd_addr_q <= '0;
              rd_en_q   <= 1'b1;
            end
          end
          SER_WAIT: begin
            if (lat_q == LW'(LATENCY - 1)) begin
              st_q    <= SER_SEND;
              pos_q   <= '0;
              sd_q    <= 1'b0;
              first_q <= 1'b1;
            end else begin
              lat_q <= lat_q + 1'b1;
              sd_q  <= 1'b1;
            end
          end
          SER_SEND: begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == PW'(0)) begin
              sd_q <= 1'b1;
              sh_q <= load_w;
            end else if (pos_q <= PW'(SH_W)) begin
              sd_q <= sh_q[SH_W-1];
              sh_q <= sh_q << 1;
            end else if (pos_q == PW'(FL - 2)) begin
              sd_q <= 1'b1;
              if (frame_q != AW'(LAST_F)) begin
                rd_addr_q <= frame_q + 1'b1;
                rd_en_q   <= 1'b1;
              end
            end else if (pos_q == PW'(FL - 1)) begin
              if (frame_q == AW'(LAST_F)) begin
                st_q <= SER_IDLE;
                sd_q <= 1'b1;
              end else begin
                frame_q <= frame_q + 1'b1;
                pos_q   <= '0;
                sd_q    <= 1'b0;
              end
            end else begin
              sd_q <= 1'b1;
            end
          end
          default: begin
            st_q <= SER_IDLE;
            sd_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign mem_rd_en   = rd_en_q;
  assign mem_addr    = rd_addr_q;
  assign first_start = first_q;
  assign busy        = (st_q != SER_IDLE);
  assign sd_out      = sd_q;
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int FRAME_BITS = 8,
  parameter int STATE_BITS = 4,
  parameter bit STATE_EN   = 1'b1,
  parameter int NUM_FRAMES = 4,
  parameter int LATENCY    = 4,
  parameter int MIN_HIGH   = 2,
  parameter int AW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_req_n,
  input  logic                  port_en,
  input  logic [1:0]            perm_mode,
  input  logic [STATE_BITS-1:0] state_in,
  output logic                  mem_rd_en,
  output logic [AW-1:0]         mem_addr,
  input  logic [FRAME_BITS-1:0] mem_rd_data,
  output logic                  sd_out
);
  logic fall_ok_w;
  logic go_w;
  logic used_w;
  logic first_w;
  logic busy_w;
  logic stop_w;

  assign stop_w = rd_req_n | port_en;

  rb_req_detect #(.MIN_HIGH(MIN_HIGH)) u_det (
    .clk      (clk),
    .rst      (rst),
    .rd_req_n (rd_req_n),
    .fall_ok  (fall_ok_w)
  );

  rb_permit u_perm (
    .clk         (clk),
    .rst         (rst),
    .perm_mode   (perm_mode),
    .req_ok      (fall_ok_w),
    .port_en     (port_en),
    .first_start (first_w),
    .go          (go_w),
    .used_q      (used_w)
  );

  rb_serializer #(
    .FRAME_BITS (FRAME_BITS),
    .STATE_BITS (STATE_BITS),
    .STATE_EN   (STATE_EN),
    .NUM_FRAMES (NUM_FRAMES),
    .LATENCY    (LATENCY),
    .AW         (AW)
  ) u_ser (
    .clk         (clk),
    .rst         (rst),
    .go          (go_w),
    .stop        (stop_w),
    .state_in    (state_in),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .first_start (first_w),
    .busy        (busy_w),
    .sd_out      (sd_out)
  );
endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int AW         = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req_n,
  input logic          port_en,
  input logic [1:0]    perm_mode,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          sd_out,
  input logic          busy,
  input logic          used
);
  // R13: processor port forces the line idle on the next cycle
  a_r13_port_idle: assert property (@(posedge clk) disable iff (rst)
    port_en |=> sd_out);

  // R7: released request stops the stream
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (rst)
    rd_req_n |=> sd_out);

  // R6: read address stays inside the frame range
  a_r6_addr_range: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (int'(mem_addr) < NUM_FRAMES));

  // R10: prohibit mode never leaves idle
  a_r10_prohibit: assert property (@(posedge clk) disable iff (rst)
    (perm_mode == 2'b00 && !busy) |=> !busy);

  // R11: once the single readback is used, idle persists
  a_r11_once_spent: assert property (@(posedge clk) disable iff (rst)
    (perm_mode == 2'b01 && used && !busy) |=> !busy);
endmodule

bind cfg_readback cfg_readback_chk #(.NUM_FRAMES(NUM_FRAMES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req_n  (rd_req_n),
  .port_en   (port_en),
  .perm_mode (perm_mode),
  .mem_rd_en (mem_rd_en),
  .mem_addr  (mem_addr),
  .sd_out    (sd_out),
  .busy      (busy_w),
  .used      (used_w)
);

// File: tb/cfg_readback_tb.sv
`timescale 1ns/1ps
module cfg_readback_tb;
  localparam int FB = 8;
  localparam int SB = 4;
  localparam int NF = 4;
  localparam int LAT = 4;
  localparam int AW = 2;
  localparam int FL = FB + SB + 4;
  localparam int STREAM = LAT + NF * FL + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req_n = 1'b0;
  logic          port_en = 1'b0;
  logic [1:0]    perm_mode = 2'b10;
  logic [SB-1:0] state_in = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [FB-1:0] mem_q = '0;
  logic          sd_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_readback #(
    .FRAME_BITS(FB), .STATE_BITS(SB), .STATE_EN(1'b1),
    .NUM_FRAMES(NF), .LATENCY(LAT), .MIN_HIGH(2), .AW(AW)
  ) u_dut (
    .clk(clk), .rst(rst), .rd_req_n(rd_req_n), .port_en(port_en),
    .perm_mode(perm_mode), .state_in(state_in), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_q), .sd_out(sd_out)
  );

  function automatic logic [FB-1:0] fword(int f);
    return FB'((f * 91 + 17) ^ 8'hC6);
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_q <= fword(int'(mem_addr));

  function automatic bit exp_bit(int j, logic [SB-1:0] st);
    int k, f, p;
    if (j < LAT) return 1'b1;
    k = j - LAT;
    f = k / FL;
    p = k % FL;
    if (f >= NF) return 1'b1;
    if (p < 2) return (p == 1);
    if (p < 2 + FB) return fword(f)[FB - 1 - (p - 2)];
    if (p < 2 + FB + SB) return st[SB - 1 - (p - 2 - FB)];
    return 1'b1;
  endfunction

  task automatic chk(bit act, bit exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // assumes caller is at a negedge with rd_req_n just driven low
  task automatic check_stream(bit served, int ncyc, string req);
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk);
      chk(sd_out, served ? exp_bit(j, state_in) : 1'b1, req);
    end
  endtask

  task automatic hold_high(int n, string req);
    rd_req_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(sd_out, 1'b1, req);
    end
    rd_req_n = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rd_req_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sd_out, 1'b1, "R1");
    chk(mem_rd_en, 1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    chk(sd_out, 1'b1, "R1");
    chk(mem_rd_en, 1'b0, "R1");
    // R2: request held low from reset starts nothing
    check_stream(1'b0, 40, "R2");

    // R3 R4 R5 R12: full stream, unlimited mode
    perm_mode = 2'b10;
    state_in = 4'hA;
    hold_high(3, "R2");
    check_stream(1'b1, STREAM, "R4");

    // R12: second request also served in mode 11
    perm_mode = 2'b11;
    state_in = 4'h5;
    hold_high(2, "R12");
    check_stream(1'b1, STREAM, "R12");

    // R7 abort mid stream, then R8 restart from frame 0
    hold_high(2, "R8");
    check_stream(1'b1, LAT + FL + 5, "R3");
    hold_high(6, "R7");
    check_stream(1'b1, STREAM, "R8");

    // R9: short pulse during a run
    hold_high(2, "R9");
    check_stream(1'b1, LAT + 9, "R9");
    rd_req_n = 1'b1;
    @(negedge clk);
    chk(sd_out, 1'b1, "R9");
    rd_req_n = 1'b0;
    check_stream(1'b0, 40, "R9");

    // R13: processor port aborts a run and blocks a start
    hold_high(2, "R13");
    check_stream(1'b1, LAT + 3, "R13");
    port_en = 1'b1;
    check_stream(1'b0, 10, "R13");
    hold_high(3, "R13");
    check_stream(1'b0, 30, "R13");
    port_en = 1'b0;
    check_stream(1'b0, 10, "R13");

    // R10: prohibit
    perm_mode = 2'b00;
    hold_high(3, "R10");
    check_stream(1'b0, 40, "R10");

    // R11: once only
    perm_mode = 2'b01;
    do_reset();
    hold_high(2, "R11");
    check_stream(1'b1, STREAM, "R11");
    hold_high(3, "R11");
    check_stream(1'b0, 40, "R11");
    // R11: spent even when aborted right after its first start bit
    do_reset();
    hold_high(2, "R11");
    check_stream(1'b1, LAT + 1, "R11");
    hold_high(3, "R11");
    check_stream(1'b0, 30, "R11");

    // random mix, unlimited mode
    perm_mode = 2'b10;
    for (int it = 0; it < 6; it++) begin
      int hl, cut;
      hl = 2 + int'($urandom_range(0, 4));
      cut = int'($urandom_range(1, STREAM));
      state_in = SB'($urandom);
      hold_high(hl, "R8");
      check_stream(1'b1, cut, "R5");
    end
    hold_high(2, "R5");
    check_stream(1'b1, STREAM + 10, "R5");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule